// File: doc/BRIEF.md
# Single-Wire Overdrive Bit Engine (Bus Master)

This block is the bit-level master of a single-wire, open-drain bus running at overdrive speed. On request it runs one of three operations: a reset pulse with a check for a device answering, a write slot that carries one bit to the device, or a read slot that fetches one bit from the device. It drives an enable that pulls the shared line low and watches the line through a synchronizer. All timing is counted in clock cycles from parameters, and the defaults assume a 1 MHz clock.

A controller above it starts an operation with a one-cycle request that carries an operation code and, for writes, the bit to send. While the engine is busy it ignores new requests. When the operation ends, including the recovery gap after the line goes high, it drops busy and raises done for one cycle. Done comes with the presence flag or the bit that was read.

Top module: `sw_bit_master`

## Requirements
- R1: After synchronous reset, `line_pull`, `busy` and `done` are all 0.
- R2: A reset operation holds `line_pull` high for T_RSTL cycles, or T_RSTL + T_FALL cycles when SLEW_COMP is 1.
- R3: A reset operation sets `result` to 1 (device present) when the line is low T_MSP cycles after the pulse ends, and to 0 when it is high. Busy lasts the low time plus T_RSTH plus T_REC cycles.
- R4: A write slot holds `line_pull` high for T_W1L cycles when `req_bit` is 1 and for T_W0L cycles when it is 0. `result` is 0 at done.
- R5: A write or read operation keeps `busy` high for exactly T_SLOT + T_REC cycles. `line_pull` is low in the final cycle before busy ends.
- R6: A read slot holds `line_pull` high for T_W1L cycles and returns in `result` the line level seen T_RDS cycles after the slot began. The synchronizer delay is absorbed inside the engine.
- R7: Every operation makes exactly one rising edge on `line_pull`, in its first busy cycle. `line_pull` is never high while `busy` is 0.
- R8: A request presented while `busy` is 1 is ignored: the running operation's pull time, length and result do not change, and it yields no extra done.
- R9: `done` is a single-cycle pulse in the cycle right after the last busy cycle. `busy` is 0 in that cycle.
- R10: Operation codes on `req_op` are 0 = reset, 1 = write, 2 = read. Code 3 is ignored and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per timing unit |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 2 | Operation code (0 reset, 1 write, 2 read) |
| req_bit | input | 1 | Bit to send for a write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 1 | Presence flag or read bit, valid with done |
| line_in | input | 1 | Raw line level (1 = high) |
| line_pull | output | 1 | Open-drain enable, 1 pulls the line low |

## Verification
The assertions assume that reset is applied from time zero, so the first clock edge sees it high. They also assume `line_in` only reads low while the engine pulls it or while a device answers. The bench models the line as the wired AND of the engine's pull and a device pull that is set before each request and held until done, so every sample point sees a settled level. Requests are driven only at falling clock edges. One deliberate request is driven mid-operation to exercise rejection.

// File: rtl/sw_bit_pkg.sv
package sw_bit_pkg;

    localparam int TW = 16;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_NONE  = 2'd3
    } sw_op_e;

    // Per-operation timing plan, all values in cycles from the slot start.
    typedef struct packed {
        logic [TW-1:0] low_end;    // pull while count is below this
        logic [TW-1:0] sample_at;  // count at which the synced line is latched
        logic [TW-1:0] last;       // final busy count
        logic          sample_en;
        logic          invert;     // presence is active low on the line
    } sw_plan_t;

    function automatic int unsigned sw_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic sw_plan_t sw_make_plan(
        input sw_op_e      op,
        input logic        wbit,
        input int unsigned rst_low,
        input int unsigned rst_high,
        input int unsigned msp,
        input int unsigned w1l,
        input int unsigned w0l,
        input int unsigned slot,
        input int unsigned rec,
        input int unsigned rds,
        input int unsigned lag
    );
        sw_plan_t p;
        p = '0;
        case (op)
            OP_RESET: begin
                p.low_end   = TW'(rst_low);
                p.sample_at = TW'(rst_low + msp + lag);
                p.last      = TW'(rst_low + rst_high + rec - 1);
                p.sample_en = 1'b1;
                p.invert    = 1'b1;
            end
            OP_WRITE: begin
                p.low_end   = wbit ? TW'(w1l) : TW'(w0l);
                p.last      = TW'(slot + rec - 1);
            end
            OP_READ: begin
                p.low_end   = TW'(w1l);
                p.sample_at = TW'(rds + lag);
                p.last      = TW'(slot + rec - 1);
                p.sample_en = 1'b1;
            end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sw_line_sync.sv
module sw_line_sync #(
    parameter int unsigned STAGES = 2,
    parameter bit          IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= IDLE;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= IDLE;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sw_slot_timer.sv
module sw_slot_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (advance) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sw_seq_ctrl.sv
module sw_seq_ctrl
    import sw_bit_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned RST_LOW  = 56,
    parameter int unsigned T_MSP    = 9,
    parameter int unsigned T_RSTH   = 48,
    parameter int unsigned T_W1L    = 1,
    parameter int unsigned T_W0L    = 8,
    parameter int unsigned T_SLOT   = 10,
    parameter int unsigned T_REC    = 2,
    parameter int unsigned T_RDS    = 2,
    parameter int unsigned SYNC_LAG = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic             req_bit,
    input  logic             line_s,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clear,
    output logic             cnt_adv,
    output logic             busy,
    output logic             done,
    output logic             result,
    output logic             pull,
    output sw_op_e           op_q
);
    sw_op_e   op_in;
    sw_plan_t plan_q;
    logic     busy_q, done_q, result_q;
    logic     accept, at_last, at_sample;
    logic [TW-1:0] cnt_w;

    assign op_in     = sw_op_e'(req_op);
    assign cnt_w     = TW'(cnt);
    assign accept    = req_valid && !busy_q && (op_in != OP_NONE);
    assign at_last   = busy_q && (cnt_w == plan_q.last);
    assign at_sample = busy_q && plan_q.sample_en && (cnt_w == plan_q.sample_at);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            result_q <= 1'b0;
            plan_q   <= '0;
            op_q     <= OP_NONE;
        end else begin
            done_q <= at_last;
            if (accept) begin
                busy_q   <= 1'b1;
                op_q     <= op_in;
                result_q <= 1'b0;
                plan_q   <= sw_make_plan(op_in, req_bit, RST_LOW, T_RSTH, T_MSP,
                                         T_W1L, T_W0L, T_SLOT, T_REC, T_RDS, SYNC_LAG);
            end else begin
                if (at_last)   busy_q   <= 1'b0;
                if (at_sample) result_q <= line_s ^ plan_q.invert;
            end
        end
    end

    assign cnt_clear = accept || at_last;
    assign cnt_adv   = busy_q;
    assign busy      = busy_q;
    assign done      = done_q;
    assign result    = result_q;
    assign pull      = busy_q && (cnt_w < plan_q.low_end);
endmodule

// File: rtl/sw_bit_master.sv
module sw_bit_master
    import sw_bit_pkg::*;
#(
    parameter int unsigned T_RSTL      = 56,
    parameter int unsigned T_FALL      = 0,
    parameter bit          SLEW_COMP   = 1'b0,
    parameter int unsigned T_MSP       = 9,
    parameter int unsigned T_RSTH      = 48,
    parameter int unsigned T_W1L       = 1,
    parameter int unsigned T_W0L       = 8,
    parameter int unsigned T_SLOT      = 10,
    parameter int unsigned T_REC       = 2,
    parameter int unsigned T_RDS       = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic       req_bit,
    output logic       busy,
    output logic       done,
    output logic       result,
    input  logic       line_in,
    output logic       line_pull
);
    localparam int unsigned RST_LOW    = T_RSTL + (SLEW_COMP ? T_FALL : 0);
    localparam int unsigned RST_TOTAL  = RST_LOW + T_RSTH + T_REC;
    localparam int unsigned SLOT_TOTAL = T_SLOT + T_REC;
    localparam int unsigned MAX_TOTAL  = sw_max(RST_TOTAL, SLOT_TOTAL);
    localparam int unsigned CNT_W      = $clog2(MAX_TOTAL + 1);

    logic             line_s;
    logic             cnt_clear, cnt_adv;
    logic [CNT_W-1:0] cnt;
    sw_op_e           op_q;

    sw_line_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_in),
        .q   (line_s)
    );

    sw_slot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (cnt_clear),
        .advance (cnt_adv),
        .cnt     (cnt)
    );

    sw_seq_ctrl #(
        .CNT_W    (CNT_W),
        .RST_LOW  (RST_LOW),
        .T_MSP    (T_MSP),
        .T_RSTH   (T_RSTH),
        .T_W1L    (T_W1L),
        .T_W0L    (T_W0L),
        .T_SLOT   (T_SLOT),
        .T_REC    (T_REC),
        .T_RDS    (T_RDS),
        .SYNC_LAG (SYNC_STAGES)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_bit   (req_bit),
        .line_s    (line_s),
        .cnt       (cnt),
        .cnt_clear (cnt_clear),
        .cnt_adv   (cnt_adv),
        .busy      (busy),
        .done      (done),
        .result    (result),
        .pull      (line_pull),
        .op_q      (op_q)
    );
endmodule

// File: rtl/sw_bit_master_chk.sv
module sw_bit_master_chk #(
    parameter int unsigned LOW_MAX = 56
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       pull,
    input logic [1:0] op_q
);
    logic [15:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || !pull) low_run <= '0;
        else              low_run <= low_run + 1'b1;
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!busy && !done && !pull));

    // R2: no pull run exceeds the longest low time
    a_r2_low_bound: assert property (@(posedge clk) disable iff (rst)
        pull |-> (32'(low_run) < LOW_MAX));

    // R5: recovery leaves the line released before busy ends
    a_r5_released_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !$past(pull));

    // R7
    a_r7_no_idle_pull: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !pull);

    a_r7_fall_at_start: assert property (@(posedge clk) disable iff (rst)
        $rose(pull) |-> $rose(busy));

    // R8
    a_r8_op_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(op_q));

    // R9
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
endmodule

bind sw_bit_master sw_bit_master_chk #(.LOW_MAX(RST_LOW)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .busy (busy),
    .done (done),
    .pull (line_pull),
    .op_q (op_q)
);

// File: tb/test_sw_bit_master.sv
module test_sw_bit_master;
    localparam int CLK_PERIOD = 10;
    localparam int T_RSTL = 56, T_FALL = 3, T_MSP = 9, T_RSTH = 48;
    localparam int T_W1L = 1, T_W0L = 8, T_SLOT = 10, T_REC = 2, T_RDS = 2;
    localparam int RL = T_RSTL + T_FALL;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic req_bit = 1'b0;
    logic slave_low = 1'b0;
    logic busy, done, result, line_pull, line_in;

    int check_cnt = 0;
    int fail_cnt  = 0;
    int m_low, m_busy, m_done, m_falls, m_idle_pull, m_busy_done, m_res;

    assign line_in = !(line_pull || slave_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    sw_bit_master #(
        .T_RSTL(T_RSTL), .T_FALL(T_FALL), .SLEW_COMP(1'b1), .T_MSP(T_MSP),
        .T_RSTH(T_RSTH), .T_W1L(T_W1L), .T_W0L(T_W0L), .T_SLOT(T_SLOT),
        .T_REC(T_REC), .T_RDS(T_RDS), .SYNC_STAGES(2)
    ) i_sw_bit_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_bit(req_bit), .busy(busy), .done(done), .result(result),
        .line_in(line_in), .line_pull(line_pull)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        check_cnt++;
        if (act != exp) begin
            fail_cnt++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_op(input int op, input int b, input int s, input bit inject);
        int after;
        bit seen;
        logic prev;
        m_low = 0; m_busy = 0; m_done = 0; m_falls = 0;
        m_idle_pull = 0; m_busy_done = 0; m_res = -1;
        after = 0; seen = 0; prev = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op[1:0]; req_bit = b[0]; slave_low = s[0];
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            if (n == 0) req_valid = 1'b0;
            if (inject && n == 3) begin req_valid = 1'b1; req_op = 2'd1; req_bit = 1'b0; end
            if (inject && n == 4) req_valid = 1'b0;
            if (line_pull) m_low++;
            if (line_pull && !prev) m_falls++;
            if (line_pull && !busy) m_idle_pull++;
            prev = line_pull;
            if (busy) m_busy++;
            if (done) begin
                m_done++;
                m_res = int'(result);
                if (busy) m_busy_done++;
                seen = 1'b1;
            end
            if (seen) begin
                after++;
                if (after > 4) break;
            end
        end
        slave_low = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", check_cnt - fail_cnt, check_cnt);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check_cnt++;
        fail_cnt++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int exp_low, exp_busy, exp_res, cnt_b, cnt_p, cnt_d;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "done after reset", int'(done), 0);
        chk("R1", "pull after reset", int'(line_pull), 0);

        // Sweep all operations, bits and device responses
        for (int op = 0; op < 3; op++) begin
            for (int b = 0; b < 2; b++) begin
                for (int s = 0; s < 2; s++) begin
                    run_op(op, b, s, 1'b0);
                    if (op == 0) begin
                        exp_low = RL;
                        exp_busy = RL + T_RSTH + T_REC;
                        exp_res = s;
                        chk("R2", "reset low time", m_low, exp_low);
                        chk("R3", "reset busy length", m_busy, exp_busy);
                        chk("R3", "presence flag", m_res, exp_res);
                    end else if (op == 1) begin
                        exp_low = (b != 0) ? T_W1L : T_W0L;
                        exp_busy = T_SLOT + T_REC;
                        chk("R4", "write low time", m_low, exp_low);
                        chk("R4", "write result", m_res, 0);
                        chk("R5", "write busy length", m_busy, exp_busy);
                    end else begin
                        exp_busy = T_SLOT + T_REC;
                        chk("R6", "read low time", m_low, T_W1L);
                        chk("R6", "read bit", m_res, (s != 0) ? 0 : 1);
                        chk("R5", "read busy length", m_busy, exp_busy);
                    end
                    chk("R7", "falling edges", m_falls, 1);
                    chk("R7", "pull while idle", m_idle_pull, 0);
                    chk("R9", "done pulses", m_done, 1);
                    chk("R9", "busy during done", m_busy_done, 0);
                end
            end
        end

        // Request while busy is ignored: write-one with a write-zero injected
        run_op(1, 1, 0, 1'b1);
        chk("R8", "low time with injected request", m_low, T_W1L);
        chk("R8", "busy length with injected request", m_busy, T_SLOT + T_REC);
        chk("R8", "done count with injected request", m_done, 1);

        // Code 3 starts nothing
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3;
        cnt_b = 0; cnt_p = 0; cnt_d = 0;
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            req_valid = 1'b0;
            cnt_b += int'(busy);
            cnt_p += int'(line_pull);
            cnt_d += int'(done);
        end
        chk("R10", "busy for code 3", cnt_b, 0);
        chk("R10", "pull for code 3", cnt_p, 0);
        chk("R10", "done for code 3", cnt_d, 0);

        finish_run();
    end
endmodule